// File: doc/BRIEF.md
# External Bus Read-Recovery Idle Inserter

This block sequences bus cycles on an external memory interface that serves eight chip-select regions. A requester hands over one access at a time through a valid/ready handshake. The sequencer then runs the phases T1, T2 and T3. During these phases it drives the active-low chip select of the addressed region.

Slow devices need time to release the data bus after a read. For this, a 16-bit control register holds one enable bit per region. When a read targets a region whose bit is set, the sequencer adds one recovery idle phase (TI) after T3. The next access cannot start until TI has finished.

Write cycles never get the idle phase. Accesses marked internal never get it either: they run the same three phases with every chip select left inactive. The enable bit is captured when the access is accepted. A register write made during a cycle therefore affects only later cycles.

Top module: `ext_bus_idle_seq`

## Requirements
- R1: After reset, `bus_phase_o` is 0 (idle), `req_ready_o` is 1, `cs_n_o` is all ones, and `cfg_rdata_o` reads 0xAAAA.
- R2: An accepted request (`req_valid_i` and `req_ready_o` both high at a clock edge) makes `bus_phase_o` go through 1 (T1), 2 (T2) and 3 (T3) on the following three cycles.
- R3: An external read to region n adds exactly one cycle with `bus_phase_o` = 4 (TI) after T3 when bit 2n+1 of the control register was 1 at acceptance. After TI the phase returns to 0.
- R4: An external read to a region whose enable bit is 0 returns from T3 directly to phase 0.
- R5: A write cycle (`req_write_i` = 1) never enters TI, whatever the register holds.
- R6: An internal access (`req_internal_i` = 1) never enters TI, and `cs_n_o` stays all ones throughout it.
- R7: During T1 to T3 of an external access to region n, only bit n of `cs_n_o` is 0. In idle and in TI, all bits are 1.
- R8: A register write (`cfg_we_i`) stores the full 16-bit word. Writes to even bit positions are ignored, and those bits always read back as 0.
- R9: `req_ready_o` is 1 only in phase 0. No new T1 starts while TI is in progress.
- R10: `rd_valid_o` is 1 exactly in the T3 cycle of a read, and 0 in all other cycles.
- R11: `cycle_done_o` pulses for one cycle in the last phase of each access: in TI if TI is added, otherwise in T3.
- R12: The enable bit is sampled when the access is accepted. Changing the register during the cycle does not alter that cycle's idle insertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request valid |
| req_ready_o | output | 1 | Sequencer can accept a request |
| req_write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| req_internal_i | input | 1 | Access targets internal space |
| req_region_i | input | 3 | Chip-select region index |
| cfg_we_i | input | 1 | Control register write strobe (full 16-bit) |
| cfg_wdata_i | input | 16 | Control register write data |
| cfg_rdata_o | output | 16 | Control register contents |
| cs_n_o | output | 8 | Active-low chip selects, one per region |
| bus_phase_o | output | 3 | Phase: 0 idle, 1 T1, 2 T2, 3 T3, 4 TI |
| rd_valid_o | output | 1 | Read data valid strobe (T3 of reads) |
| cycle_done_o | output | 1 | Final phase of the current access |

## Verification
The hardest case to reach is R12. Here the register changes while an access is already in flight, and the captured enable bit must win over the new contents. The bench issues a read to a region that is enabled. In the T1 cycle it writes a register value that clears that region's bit. It then checks that TI still follows. A second read to the same region must then run without TI. The reverse order is covered the same way: a disabled region is read, and its bit is set in the middle of the cycle.

// File: rtl/ext_bus_idle_pkg.sv
package ext_bus_idle_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TI   = 3'd4
  } bus_phase_e;
endpackage

// File: rtl/idle_ctrl_reg.sv
module idle_ctrl_reg #(
  parameter int NUM_CS = 8,
  localparam int REG_W = 2 * NUM_CS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o
);
  // odd bits hold enables, even bits are tied low
  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (b % 2 == 1) begin : g_en
      logic en_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   en_q <= 1'b1;
        else if (we_i) en_q <= wdata_i[b];
      end
      assign rdata_o[b] = en_q;
    end else begin : g_zero
      assign rdata_o[b] = 1'b0;
    end
  end

  function automatic logic [REG_W-1:0] odd_mask();
    logic [REG_W-1:0] m;
    for (int i = 0; i < REG_W; i++) m[i] = (i % 2 == 1);
    return m;
  endfunction

  assert_write_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o == ($past(wdata_i) & odd_mask()));
endmodule

// File: rtl/cs_decode.sv
module cs_decode #(
  parameter int NUM_CS = 8,
  localparam int REGION_W = $clog2(NUM_CS)
) (
  input  logic                active_i,
  input  logic [REGION_W-1:0] region_i,
  output logic [NUM_CS-1:0]   cs_n_o
);
  for (genvar n = 0; n < NUM_CS; n++) begin : g_cs
    assign cs_n_o[n] = !(active_i && (region_i == REGION_W'(n)));
  end
endmodule

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import ext_bus_idle_pkg::*;
#(
  parameter int NUM_CS = 8,
  localparam int REGION_W = $clog2(NUM_CS),
  localparam int REG_W = 2 * NUM_CS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic                req_internal_i,
  input  logic [REGION_W-1:0] req_region_i,
  input  logic [REG_W-1:0]    en_bits_i,
  output logic                req_ready_o,
  output bus_phase_e          phase_o,
  output logic                cs_active_o,
  output logic [REGION_W-1:0] region_o,
  output logic                rd_valid_o,
  output logic                cycle_done_o
);
  bus_phase_e          phase_q, phase_d;
  logic                write_q, int_q, idle_en_q;
  logic [REGION_W-1:0] region_q;
  logic                accept;

  assign accept = req_valid_i && (phase_q == PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (accept) phase_d = PH_T1;
      PH_T1:   phase_d = PH_T2;
      PH_T2:   phase_d = PH_T3;
      PH_T3:   phase_d = idle_en_q ? PH_TI : PH_IDLE;
      PH_TI:   phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      write_q   <= 1'b0;
      int_q     <= 1'b0;
      idle_en_q <= 1'b0;
      region_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (accept) begin
        write_q   <= req_write_i;
        int_q     <= req_internal_i;
        region_q  <= req_region_i;
        // enable captured at acceptance
        idle_en_q <= en_bits_i[{req_region_i, 1'b1}] && !req_write_i && !req_internal_i;
      end
    end
  end

  assign req_ready_o  = (phase_q == PH_IDLE);
  assign phase_o      = phase_q;
  assign region_o     = region_q;
  assign cs_active_o  = !int_q && (phase_q inside {PH_T1, PH_T2, PH_T3});
  assign rd_valid_o   = !write_q && (phase_q == PH_T3);
  assign cycle_done_o = (phase_q == PH_TI) || (phase_q == PH_T3 && !idle_en_q);

  assert_ti_follows_t3_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_TI |-> $past(phase_q) == PH_T3);
  assert_no_ti_on_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_T3 && write_q) |=> phase_q != PH_TI);
  assert_no_ti_internal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_T3 && int_q) |=> phase_q != PH_TI);
  assert_no_t1_after_ti_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_TI |=> phase_q == PH_IDLE);
endmodule

// File: rtl/ext_bus_idle_seq.sv
module ext_bus_idle_seq
  import ext_bus_idle_pkg::*;
#(
  parameter int NUM_CS = 8,
  localparam int REGION_W = $clog2(NUM_CS),
  localparam int REG_W = 2 * NUM_CS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_write_i,
  input  logic                req_internal_i,
  input  logic [REGION_W-1:0] req_region_i,
  input  logic                cfg_we_i,
  input  logic [REG_W-1:0]    cfg_wdata_i,
  output logic [REG_W-1:0]    cfg_rdata_o,
  output logic [NUM_CS-1:0]   cs_n_o,
  output logic [2:0]          bus_phase_o,
  output logic                rd_valid_o,
  output logic                cycle_done_o
);
  bus_phase_e          phase;
  logic                cs_active;
  logic [REGION_W-1:0] cur_region;

  idle_ctrl_reg #(.NUM_CS(NUM_CS)) i_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wdata_i(cfg_wdata_i),
    .rdata_o(cfg_rdata_o)
  );

  bus_seq_fsm #(.NUM_CS(NUM_CS)) i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_write_i   (req_write_i),
    .req_internal_i(req_internal_i),
    .req_region_i  (req_region_i),
    .en_bits_i     (cfg_rdata_o),
    .req_ready_o   (req_ready_o),
    .phase_o       (phase),
    .cs_active_o   (cs_active),
    .region_o      (cur_region),
    .rd_valid_o    (rd_valid_o),
    .cycle_done_o  (cycle_done_o)
  );

  cs_decode #(.NUM_CS(NUM_CS)) i_cs (
    .active_i(cs_active),
    .region_i(cur_region),
    .cs_n_o  (cs_n_o)
  );

  assign bus_phase_o = phase;

  assert_accept_t1_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> bus_phase_o == 3'd1);
  assert_cs_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
  assert_cs_off_in_ti_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_phase_o == 3'd4 |-> &cs_n_o);
  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_done_o |=> !cycle_done_o);
endmodule

// File: tb/test_ext_bus_idle_seq.sv
module test_ext_bus_idle_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic        req_internal_i = 1'b0;
  logic [2:0]  req_region_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic [15:0] cfg_rdata_o;
  logic [7:0]  cs_n_o;
  logic [2:0]  bus_phase_o;
  logic        rd_valid_o;
  logic        cycle_done_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [15:0] model = 16'hAAAA;

  ext_bus_idle_seq i_ext_bus_idle_seq (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [15:0] v);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    model = v & 16'hAAAA;
    chk("R8 rdata", cfg_rdata_o, model);
  endtask

  // one access; mid_cfg: register write issued during T1
  task automatic access(logic wr, logic intl, logic [2:0] rg,
                        logic mid_cfg, logic [15:0] mid_val);
    logic exp_ti;
    logic [7:0] exp_cs;
    exp_ti = model[2*rg+1] && !wr && !intl;
    exp_cs = intl ? 8'hFF : ~(8'h1 << rg);
    @(negedge clk_i);
    chk("R9 ready idle", req_ready_o, 1);
    req_valid_i = 1'b1; req_write_i = wr; req_internal_i = intl; req_region_i = rg;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R2 T1", bus_phase_o, 1);
    chk("R7 cs T1", cs_n_o, exp_cs);
    chk("R6/R7 internal cs", &cs_n_o, intl ? 1 : 0);
    chk("R9 busy", req_ready_o, 0);
    if (mid_cfg) begin cfg_we_i = 1'b1; cfg_wdata_i = mid_val; end
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (mid_cfg) model = mid_val & 16'hAAAA;
    chk("R2 T2", bus_phase_o, 2);
    chk("R10 no rdv T2", rd_valid_o, 0);
    @(negedge clk_i);
    chk("R2 T3", bus_phase_o, 3);
    chk("R7 cs T3", cs_n_o, exp_cs);
    chk("R10 rdv T3", rd_valid_o, !wr);
    chk("R11 done T3", cycle_done_o, !exp_ti);
    @(negedge clk_i);
    if (exp_ti) begin
      chk("R3/R12 TI", bus_phase_o, 4);
      chk("R7 cs TI", cs_n_o, 8'hFF);
      chk("R9 no ready TI", req_ready_o, 0);
      chk("R11 done TI", cycle_done_o, 1);
      chk("R10 no rdv TI", rd_valid_o, 0);
      @(negedge clk_i);
    end
    chk("R4/R5/R6 back idle", bus_phase_o, 0);
    chk("R11 done low", cycle_done_o, 0);
  endtask

  task automatic t_reset;
    chk("R1 phase", bus_phase_o, 0);
    chk("R1 ready", req_ready_o, 1);
    chk("R1 cs", cs_n_o, 8'hFF);
    chk("R1 cfg", cfg_rdata_o, 16'hAAAA);
  endtask

  task automatic t_reads_enabled;
    for (int r = 0; r < 8; r++) access(0, 0, 3'(r), 0, 0); // R3
  endtask

  task automatic t_reads_disabled;
    cfg_write(16'h5555); // R8 even bits only -> 0
    access(0, 0, 3'd2, 0, 0); // R4
    cfg_write(16'hFFFF);
    access(0, 0, 3'd7, 0, 0); // R3
    cfg_write(16'h0008); // only region 1 enabled
    access(0, 0, 3'd1, 0, 0);
    access(0, 0, 3'd0, 0, 0);
  endtask

  task automatic t_writes_internal;
    cfg_write(16'hAAAA);
    access(1, 0, 3'd4, 0, 0); // R5
    access(0, 1, 3'd3, 0, 0); // R6
    access(1, 1, 3'd6, 0, 0);
  endtask

  task automatic t_mid_change;
    // R12: enabled at accept, cleared during cycle -> TI still present
    access(0, 0, 3'd5, 1, 16'h0000);
    access(0, 0, 3'd5, 0, 0);
    // disabled at accept, set during cycle -> no TI
    access(0, 0, 3'd5, 1, 16'hAAAA);
    access(0, 0, 3'd5, 0, 0);
  endtask

  task automatic t_back_to_back;
    // R9: request held during TI is only accepted after TI
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 0; req_internal_i = 0; req_region_i = 3'd0;
    repeat (4) @(negedge clk_i);
    chk("R9 TI with valid held", bus_phase_o, 4);
    @(negedge clk_i);
    chk("R9 idle before T1", bus_phase_o, 0);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R9 next T1", bus_phase_o, 1);
    repeat (4) @(negedge clk_i);
    chk("R9 idle end", bus_phase_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_reads_enabled;
    t_reads_disabled;
    t_writes_internal;
    t_mid_change;
    t_back_to_back;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule